// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block sits next to a small processor core and arbitrates six maskable interrupt sources. Two come from external pins, each watched for a configurable edge. Two are timer overflow pulses. One is a serial-transfer-complete pulse and one is a multi-function request. Each source has a request flag and an enable bit. These bits, together with one master enable, live in two 8-bit control registers that software can write and read back.

The core asserts a sample strobe once per instruction phase. On a strobe edge the controller considers every source whose flag, own enable and the master enable are all set, provided the core reports that its return stack is not full. The highest-priority such source wins. Its flag and the master enable are cleared. One clock later the controller raises a single-cycle acknowledge and presents that source's vector address. Further acknowledges stay blocked until an interrupt-type return, or a software write, sets the master enable again. A plain return does not set it.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, both control registers read 0x00, `ack` is low and `vec` is 0x00.
- R2: Control register 0 holds master enable in bit 0, the enables for external 0, external 1 and timer 0 in bits 1..3, and their flags in bits 4..6. Control register 1 holds the enables for timer 1, serial and multi-function in bits 0..2, and their flags in bits 4..6. Bits 7 of both registers and bit 3 of register 1 always read 0. A write is visible on the readback port after the next clock edge.
- R3: A one-cycle high on `tmr0_ovf`, `tmr1_ovf`, `ser_done` or `mf_req` sets control register 0 bit 6, register 1 bit 4, register 1 bit 5 or register 1 bit 6 respectively.
- R4: Each external pin sets its flag on the edge chosen by its parameter: code 0 means falling only, 1 rising only, 2 either edge. The defaults are falling only for external 0 and either edge for external 1. The other edge leaves the flag unchanged.
- R5: An acknowledge is issued only for a clock edge at which `sample_stb` is high, `stack_full` is low, the master enable is set, and at least one source has both its flag and its enable set. Pending requests are held until such a strobe.
- R6: When several sources qualify together, the winner follows the order external 0, external 1, timer 0, timer 1, serial, multi-function. The vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 respectively. `vec` holds the last vector.
- R7: The acknowledge is a one-cycle pulse. In the same update it clears the winning flag and the master enable, and leaves all other flags unchanged.
- R8: A return with `ret_is_irq` high sets the master enable. A return with `ret_is_irq` low leaves it unchanged.
- R9: A hardware event that sets a flag in the same cycle as a software write of 0 to that flag leaves the flag set.
- R10: While the master enable is clear, strobes issue no acknowledge even with requests pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_pin | input | 1 | External request pin 0 |
| ext1_pin | input | 1 | External request pin 1 |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_done | input | 1 | Serial transfer complete pulse |
| mf_req | input | 1 | Multi-function request pulse |
| wr_ctl0 | input | 1 | Write strobe for control register 0 |
| wr_ctl1 | input | 1 | Write strobe for control register 1 |
| wdata | input | 8 | Write data |
| ctl0 | output | 8 | Control register 0 readback |
| ctl1 | output | 8 | Control register 1 readback |
| sample_stb | input | 1 | Core phase strobe on which requests are sampled |
| stack_full | input | 1 | Core return stack is full |
| ret_valid | input | 1 | Core executes a return |
| ret_is_irq | input | 1 | The return is an interrupt return |
| ack | output | 1 | One-cycle acknowledge to the core |
| vec | output | VW (8) | Vector address of the last acknowledged source |

## Verification
Directed sequences raise one request at a time. This separates the flag bit positions, the edge selection on each pin and the vector of each source. They also raise three requests at once and serve them one return at a time, which exposes the priority order and the clearing of only the winning flag. Blocking cases use a full stack, no strobe, a cleared master enable and a plain return, and show that each gating term is honoured on its own. A software clear that coincides with a timer pulse checks the set-over-clear rule. A long constrained-random run then mixes pin toggles, pulses, writes, strobes and returns against a cycle model, to catch interactions the directed cases miss.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int EXT0_EDGE = 0,
  parameter int EXT1_EDGE = 2,
  parameter int VW        = 8,
  parameter int VEC_BASE  = 4,
  parameter int VEC_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext0_pin,
  input  logic          ext1_pin,
  input  logic          tmr0_ovf,
  input  logic          tmr1_ovf,
  input  logic          ser_done,
  input  logic          mf_req,
  input  logic          wr_ctl0,
  input  logic          wr_ctl1,
  input  logic [7:0]    wdata,
  output logic [7:0]    ctl0,
  output logic [7:0]    ctl1,
  input  logic          sample_stb,
  input  logic          stack_full,
  input  logic          ret_valid,
  input  logic          ret_is_irq,
  output logic          ack,
  output logic [VW-1:0] vec
);
  localparam int NSRC = 6;
  localparam int HALF = NSRC / 2;
  localparam int SW   = $clog2(NSRC);

  function automatic logic edge_hit(int mode, logic cur, logic prev);
    case (mode)
      0:       return prev & ~cur;
      1:       return cur & ~prev;
      default: return cur ^ prev;
    endcase
  endfunction

  logic [NSRC-1:0] flag_q, en_q, flag_nxt, pend, clr_mask, hw_set;
  logic            me_q, pin0_q, pin1_q, ack_q, take;
  logic [SW-1:0]   sel;
  logic [VW-1:0]   vec_q;

  wire wdata_unused = wdata[7] ^ wdata[3];

  assign hw_set = {mf_req, ser_done, tmr1_ovf, tmr0_ovf,
                   edge_hit(EXT1_EDGE, ext1_pin, pin1_q),
                   edge_hit(EXT0_EDGE, ext0_pin, pin0_q)};
  assign pend     = flag_q & en_q & {NSRC{me_q & ~stack_full}};
  assign take     = sample_stb & (|pend);
  assign clr_mask = take ? (NSRC'(1) << sel) : '0;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) sel = SW'(i);
  end

  always_comb begin
    flag_nxt = flag_q;
    if (wr_ctl0) flag_nxt[HALF-1:0]    = wdata[4 +: HALF];
    if (wr_ctl1) flag_nxt[NSRC-1:HALF] = wdata[4 +: HALF];
    flag_nxt = (flag_nxt & ~clr_mask) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      me_q   <= 1'b0;
      pin0_q <= 1'b0;
      pin1_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      pin0_q <= ext0_pin;
      pin1_q <= ext1_pin;
      flag_q <= flag_nxt;
      if (wr_ctl0) en_q[HALF-1:0]    <= wdata[3:1];
      if (wr_ctl1) en_q[NSRC-1:HALF] <= wdata[2:0];
      if (take)                        me_q <= 1'b0;
      else if (ret_valid && ret_is_irq) me_q <= 1'b1;
      else if (wr_ctl0)                me_q <= wdata[0];
      ack_q <= take;
      if (take) vec_q <= VW'(VEC_BASE + VEC_STEP * int'(sel));
    end
  end

  assign ctl0 = {1'b0, flag_q[HALF-1:0], en_q[HALF-1:0], me_q};
  assign ctl1 = {1'b0, flag_q[NSRC-1:HALF], 1'b0, en_q[NSRC-1:HALF]};
  assign ack  = ack_q;
  assign vec  = vec_q;
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic          stack_full,
  input logic          ret_valid,
  input logic          ret_is_irq,
  input logic [7:0]    ctl0,
  input logic [7:0]    ctl1,
  input logic          ack,
  input logic [VW-1:0] vec
);
  a_r5_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(sample_stb) && !$past(stack_full) && $past(ctl0[0])));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r7_master_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ctl0[0]);

  a_r6_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec[1:0] == 2'b00 && vec >= VW'(4) && vec <= VW'(24)));

  a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_is_irq && !sample_stb) |=> ctl0[0]);

  a_r10_no_ack_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl0[0] |=> !ack);

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl0[7] && !ctl1[7] && !ctl1[3]));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .stack_full(stack_full),
  .ret_valid(ret_valid), .ret_is_irq(ret_is_irq), .ctl0(ctl0), .ctl1(ctl1),
  .ack(ack), .vec(vec)
);

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_pin = 0, ext1_pin = 0, tmr0_ovf = 0, tmr1_ovf = 0, ser_done = 0, mf_req = 0;
  logic wr_ctl0 = 0, wr_ctl1 = 0, sample_stb = 0, stack_full = 0, ret_valid = 0, ret_is_irq = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ctl0, ctl1, vec;
  logic ack;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_ctl i_irq_vector_ctl (
    .clk(clk), .rst_n(rst_n), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .ser_done(ser_done), .mf_req(mf_req),
    .wr_ctl0(wr_ctl0), .wr_ctl1(wr_ctl1), .wdata(wdata), .ctl0(ctl0), .ctl1(ctl1),
    .sample_stb(sample_stb), .stack_full(stack_full), .ret_valid(ret_valid),
    .ret_is_irq(ret_is_irq), .ack(ack), .vec(vec)
  );

  // reference model built from the requirements
  logic [5:0] m_f, m_en;
  logic m_me, m_p0, m_p1, m_ack, m_ok = 0;
  logic [7:0] m_vec;

  function automatic logic [7:0] exp_ctl0(logic [5:0] f, logic [5:0] e, logic me);
    return {1'b0, f[2:0], e[2:0], me};
  endfunction
  function automatic logic [7:0] exp_ctl1(logic [5:0] f, logic [5:0] e);
    return {1'b0, f[5:3], 1'b0, e[5:3]};
  endfunction
  function automatic int winner(logic [5:0] p);
    for (int i = 0; i < 6; i++) if (p[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_f <= 0; m_en <= 0; m_me <= 0; m_p0 <= 0; m_p1 <= 0; m_ack <= 0; m_vec <= 0; m_ok <= 1;
    end else begin
      logic [5:0] pend, nf, hw;
      int w;
      pend = m_f & m_en & {6{m_me & ~stack_full}};
      w = sample_stb ? winner(pend) : -1;
      hw = {mf_req, ser_done, tmr1_ovf, tmr0_ovf, ext1_pin ^ m_p1, m_p0 & ~ext0_pin};
      nf = m_f;
      if (wr_ctl0) nf[2:0] = wdata[6:4];
      if (wr_ctl1) nf[5:3] = wdata[6:4];
      if (w >= 0) nf[w] = 1'b0;
      nf |= hw;
      m_f <= nf;
      if (wr_ctl0) m_en[2:0] <= wdata[3:1];
      if (wr_ctl1) m_en[5:3] <= wdata[2:0];
      if (w >= 0) m_me <= 0;
      else if (ret_valid && ret_is_irq) m_me <= 1;
      else if (wr_ctl0) m_me <= wdata[0];
      m_ack <= (w >= 0);
      if (w >= 0) m_vec <= 8'(4 * (w + 1));
      m_p0 <= ext0_pin; m_p1 <= ext1_pin;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && m_ok && !done) begin
    check("R2/R3/R7 ctl0 model", ctl0, exp_ctl0(m_f, m_en, m_me));
    check("R2/R3/R7 ctl1 model", ctl1, exp_ctl1(m_f, m_en));
    check("R5 ack model", {7'd0, ack}, {7'd0, m_ack});
    check("R6 vec model", vec, m_vec);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(bit which, logic [7:0] d);
    if (which) wr_ctl1 = 1; else wr_ctl0 = 1;
    wdata = d; step(); wr_ctl0 = 0; wr_ctl1 = 0;
  endtask
  task automatic strobe();
    sample_stb = 1; step(); sample_stb = 0;
  endtask
  task automatic do_ret(bit irq);
    ret_valid = 1; ret_is_irq = irq; step(); ret_valid = 0; ret_is_irq = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    step(3); rst_n = 1; step();
    check("R1 reset ctl0", ctl0, 8'h00);
    check("R1 reset ctl1", ctl1, 8'h00);
    check("R1 reset ack", {7'd0, ack}, 8'h00);
    check("R1 reset vec", vec, 8'h00);

    wr(0, 8'h0F); check("R2 ctl0 readback", ctl0, 8'h0F);
    wr(1, 8'hFF); check("R2 ctl1 unused bits zero", ctl1, 8'h77);
    wr(1, 8'h07); check("R2 ctl1 readback", ctl1, 8'h07);

    tmr1_ovf = 1; step(); tmr1_ovf = 0;
    check("R3 timer1 flag bit4", ctl1, 8'h17);
    stack_full = 1; strobe(); stack_full = 0;
    check("R5 stack full blocks", {7'd0, ack}, 8'h00);
    step(2); check("R5 no strobe no ack", {7'd0, ack}, 8'h00);
    strobe();
    check("R5 ack issued", {7'd0, ack}, 8'h01);
    check("R6 timer1 vector", vec, 8'h10);
    check("R7 ctl1 flag cleared", ctl1, 8'h07);
    check("R7 master cleared", ctl0, 8'h0E);
    step(); check("R7 ack one cycle", {7'd0, ack}, 8'h00);

    ext0_pin = 1; step(); check("R4 ext0 rising ignored", ctl0, 8'h0E);
    ext0_pin = 0; step(); check("R4 ext0 falling sets", ctl0, 8'h1E);
    ext1_pin = 1; step(); check("R4 ext1 rising sets", ctl0, 8'h3E);
    tmr0_ovf = 1; step(); tmr0_ovf = 0; check("R3 timer0 flag bit6", ctl0, 8'h7E);
    strobe(); check("R10 masked no ack", {7'd0, ack}, 8'h00);
    do_ret(0); check("R8 plain return keeps master", ctl0, 8'h7E);
    do_ret(1); check("R8 irq return sets master", ctl0, 8'h7F);
    strobe();
    check("R6 ext0 first", vec, 8'h04);
    check("R7 only ext0 flag cleared", ctl0, 8'h6E);
    do_ret(1); strobe();
    check("R6 ext1 second", vec, 8'h08);
    check("R7 ext1 flag cleared", ctl0, 8'h4E);
    do_ret(1); strobe();
    check("R6 timer0 third", vec, 8'h0C);
    check("R7 timer0 flag cleared", ctl0, 8'h0E);

    ext1_pin = 0; step(); check("R4 ext1 falling sets", ctl0, 8'h2E);
    tmr0_ovf = 1; wr(0, 8'h0E); tmr0_ovf = 0;
    check("R9 set beats software clear", ctl0, 8'h4E);
    ser_done = 1; mf_req = 1; step(); ser_done = 0; mf_req = 0;
    check("R3 serial and mf flags", ctl1, 8'h67);
    wr(0, 8'h00); wr(1, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      ext0_pin   = ($urandom % 8 == 0) ? ~ext0_pin : ext0_pin;
      ext1_pin   = ($urandom % 8 == 0) ? ~ext1_pin : ext1_pin;
      tmr0_ovf   = ($urandom % 10 == 0);
      tmr1_ovf   = ($urandom % 10 == 0);
      ser_done   = ($urandom % 10 == 0);
      mf_req     = ($urandom % 10 == 0);
      wr_ctl0    = ($urandom % 16 == 0);
      wr_ctl1    = ($urandom % 16 == 0);
      wdata      = 8'($urandom);
      sample_stb = ($urandom % 4 == 0);
      stack_full = ($urandom % 4 == 0);
      ret_valid  = ($urandom % 12 == 0);
      ret_is_irq = ($urandom % 2 == 0);
      step();
    end
    {tmr0_ovf, tmr1_ovf, ser_done, mf_req, wr_ctl0, wr_ctl1, sample_stb, ret_valid} = '0;
    step(2);
    finish_run();
  end
endmodule